// File: doc/BRIEF.md
# Linear CCD Drive and Readout Sequencer

This block produces the digital clock waveforms for a three-colour linear CCD whose shift registers feed a pair of outputs per colour, one carrying even elements and one carrying odd elements. It runs from one fast master clock. Every drive edge is placed by counting master ticks against plain configuration inputs. The outputs are the two complementary main shift phases, a separate pair of last-stage clocks, two reset clocks, and three transfer-gate pulses that always move together.

A line begins with a transfer-gate pulse that moves charge from the photocells into the shift registers. The shift clocks stay static for a guard interval before the pulse and for another one after it. The readout then steps through a fixed layout of elements. First come the vacant-transfer elements, then the optical-black ones, then a few invalid ones, and last the active photo elements (26, 96, 6 and 5000 by default). For every element the block tags the sample cycle with the element index, a region code and the output (even or odd) that carries it.

The tag stream is valid-only and has no ready input. The sensor cannot be stalled, so a consumer must accept a tag in the cycle `smp_valid` is high. A line-start request may come at any time. It is remembered until the current line ends and the programmed integration time has elapsed.

Top module: `lccd_seq`

## Requirements
- R1: During readout the element index `smp_idx` runs from 0 to TOTAL-1 in steps of one. `smp_region` is 0 for indices below N_VACANT, 1 for the next N_BLACK, 2 for the next N_INVALID and 3 for the N_ACTIVE indices that remain.
- R2: Each element lasts `cfg_half` master ticks. `smp_valid` is high for one tick, on the last tick of each element, and `smp_odd` equals bit 0 of the element index.
- R3: During readout `sh1` is high for even elements and `sh2` is high for odd elements, and the two are always complementary. Outside readout they rest at `sh1`=1 and `sh2`=0.
- R4: With `cfg_hs`=0, `last1` and `last2` follow `sh1` and `sh2`. With `cfg_hs`=1, each last-stage clock falls `cfg_lead` ticks before the end of its element while the main phase is still high. Outside readout they rest at `last1`=1 and `last2`=0.
- R5: `rst_a` is high for the first `cfg_rst_w` ticks of each even element and `rst_b` for the first `cfg_rst_w` ticks of each odd element. Both are low at all other times, so each reset clock falls before the last-stage clock of its own element.
- R6: All three `tg` bits rise and fall together and stay high for `cfg_tg_w` ticks. The high pulse has `cfg_guard` static ticks before it and `cfg_guard` static ticks after it, and the first element of the readout follows at once.
- R7: When the block is idle and the integration time has elapsed, a `line_req` seen at a clock edge starts the leading guard interval in the next cycle. A request that arrives during a line is kept and starts the next line after the current one ends.
- R8: The integration count starts from zero in the first cycle after the transfer-gate pulse. A new leading guard interval begins no earlier than `cfg_integ`+1 cycles after the first cycle in which `tg` is low again.
- R9: `line_done` is high for exactly one cycle, the cycle after the sample tick of element TOTAL-1.
- R10: After reset the block is idle: the shift and last-stage clocks are at rest, and `tg`, the reset clocks, `smp_valid` and `line_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_req | input | 1 | Request to start a line |
| cfg_hs | input | 1 | High-speed mode: advance last-stage falling edges |
| cfg_half | input | TICK_W | Master ticks per element |
| cfg_lead | input | TICK_W | Last-stage advance in ticks (high-speed mode) |
| cfg_rst_w | input | TICK_W | Reset clock high width in ticks |
| cfg_tg_w | input | TICK_W | Transfer-gate pulse width in ticks |
| cfg_guard | input | TICK_W | Static interval before and after the transfer-gate pulse |
| cfg_integ | input | INTEG_W | Minimum integration time in ticks |
| sh1 | output | 1 | Main shift clock, phase 1 |
| sh2 | output | 1 | Main shift clock, phase 2 |
| last1 | output | 1 | Last-stage clock, phase 1 |
| last2 | output | 1 | Last-stage clock, phase 2 |
| rst_a | output | 1 | Reset clock for the even-element output |
| rst_b | output | 1 | Reset clock for the odd-element output |
| tg | output | N_COLOUR | Transfer-gate pulses, one per colour |
| smp_valid | output | 1 | Sample tick of the current element |
| smp_odd | output | 1 | 1 when the element leaves on the odd output |
| smp_region | output | 2 | Region code of the element |
| smp_idx | output | IDX_W | Element index within the line |
| line_done | output | 1 | One-cycle pulse after the last element |

## Verification
The assertions assume the configuration is legal and stays stable while a line runs. All counts must be at least one. The lead must be smaller than `cfg_half`, and the reset width must be smaller than `cfg_half` minus the lead in high-speed mode, or smaller than `cfg_half` otherwise. If the reset width reached the last-stage edge, the two falling edges could meet in the same tick and the edge-ordering checks would fire. The stimulus changes configuration only while the block is idle. Every configuration it uses keeps a gap of at least one tick between the reset edge and the last-stage edge. It sends line requests only as single-cycle pulses.

// File: rtl/lccd_pkg.sv
package lccd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TG, ST_POST, ST_READ
  } seq_st_t;

  typedef enum logic [1:0] {
    RG_VACANT  = 2'd0,
    RG_BLACK   = 2'd1,
    RG_INVALID = 2'd2,
    RG_ACTIVE  = 2'd3
  } region_t;
endpackage

// File: rtl/lccd_line_fsm.sv
module lccd_line_fsm
  import lccd_pkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int INTEG_W = 20,
  parameter int TOTAL   = 5128,
  parameter int IDX_W   = $clog2(TOTAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_req,
  input  logic [TICK_W-1:0]  cfg_half,
  input  logic [TICK_W-1:0]  cfg_tg_w,
  input  logic [TICK_W-1:0]  cfg_guard,
  input  logic [INTEG_W-1:0] cfg_integ,
  output seq_st_t            st,
  output logic [TICK_W-1:0]  tcnt,
  output logic [IDX_W-1:0]   ecnt,
  output logic               line_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic [TICK_W-1:0]  lim;
  logic [INTEG_W-1:0] integ_cnt;
  logic               pend, wrap, launch, last_elem, integ_ok;

  always_comb begin
    case (st)
      ST_PRE, ST_POST: lim = cfg_guard - 1'b1;
      ST_TG:           lim = cfg_tg_w - 1'b1;
      default:         lim = cfg_half - 1'b1;
    endcase
  end

  assign wrap      = (tcnt == lim);
  assign last_elem = (ecnt == LAST_IDX);
  assign integ_ok  = (integ_cnt >= cfg_integ);
  assign launch    = (st == ST_IDLE) && (pend || line_req) && integ_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      ecnt      <= '0;
      pend      <= 1'b0;
      integ_cnt <= '0;
      line_done <= 1'b0;
    end else begin
      line_done <= (st == ST_READ) && wrap && last_elem;
      pend      <= (pend | line_req) & ~launch;
      if (st == ST_TG) integ_cnt <= '0;
      else if (integ_cnt != '1) integ_cnt <= integ_cnt + 1'b1;
      if (st == ST_IDLE) begin
        tcnt <= '0;
        ecnt <= '0;
        if (launch) st <= ST_PRE;
      end else if (!wrap) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (st)
          ST_PRE:  st <= ST_TG;
          ST_TG:   st <= ST_POST;
          ST_POST: begin st <= ST_READ; ecnt <= '0; end
          ST_READ: begin
            if (last_elem) begin st <= ST_IDLE; ecnt <= '0; end
            else ecnt <= ecnt + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE && $past(st) == ST_IDLE) |-> $past(integ_ok));

  // R6
  tg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_TG && st != ST_TG) |-> st == ST_POST);
endmodule

// File: rtl/lccd_phase_gen.sv
module lccd_phase_gen #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reading,
  input  logic              elem_odd,
  input  logic [TICK_W-1:0] tcnt,
  input  logic [TICK_W-1:0] cfg_half,
  input  logic [TICK_W-1:0] cfg_lead,
  input  logic [TICK_W-1:0] cfg_rst_w,
  input  logic              cfg_hs,
  output logic              sh1,
  output logic              sh2,
  output logic              last1,
  output logic              last2,
  output logic              rst_a,
  output logic              rst_b
);
  logic [TICK_W-1:0] l_edge;
  logic              l_on, r_on;

  assign l_edge = cfg_hs ? (cfg_half - cfg_lead) : cfg_half;
  assign l_on   = (tcnt < l_edge);
  assign r_on   = (tcnt < cfg_rst_w);

  always_comb begin
    if (reading) begin
      sh1   = ~elem_odd;
      sh2   =  elem_odd;
      last1 = ~elem_odd & l_on;
      last2 =  elem_odd & l_on;
      rst_a = ~elem_odd & r_on;
      rst_b =  elem_odd & r_on;
    end else begin
      sh1   = 1'b1;
      sh2   = 1'b0;
      last1 = 1'b1;
      last2 = 1'b0;
      rst_a = 1'b0;
      rst_b = 1'b0;
    end
  end

  // R5
  rst_a_before_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(last1) |-> !$past(rst_a));

  // R5
  rst_b_before_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(last2) |-> !$past(rst_b));

  // R4
  hs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hs && $fell(last1)) |-> sh1);

  // R4
  aligned_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hs && $fell(last1)) |-> !sh1);
endmodule

// File: rtl/lccd_tagger.sv
module lccd_tagger
  import lccd_pkg::*;
#(
  parameter int TICK_W    = 8,
  parameter int IDX_W     = 13,
  parameter int N_VACANT  = 26,
  parameter int N_BLACK   = 96,
  parameter int N_INVALID = 6
) (
  input  logic              reading,
  input  logic [TICK_W-1:0] tcnt,
  input  logic [IDX_W-1:0]  ecnt,
  input  logic [TICK_W-1:0] cfg_half,
  output logic              smp_valid,
  output logic              smp_odd,
  output logic [1:0]        smp_region,
  output logic [IDX_W-1:0]  smp_idx
);
  localparam logic [IDX_W-1:0] B_BLACK   = IDX_W'(N_VACANT);
  localparam logic [IDX_W-1:0] B_INVALID = IDX_W'(N_VACANT + N_BLACK);
  localparam logic [IDX_W-1:0] B_ACTIVE  = IDX_W'(N_VACANT + N_BLACK + N_INVALID);

  region_t rg;

  always_comb begin
    if (ecnt < B_BLACK)        rg = RG_VACANT;
    else if (ecnt < B_INVALID) rg = RG_BLACK;
    else if (ecnt < B_ACTIVE)  rg = RG_INVALID;
    else                       rg = RG_ACTIVE;
  end

  assign smp_valid  = reading && (tcnt == cfg_half - 1'b1);
  assign smp_odd    = ecnt[0];
  assign smp_region = rg;
  assign smp_idx    = ecnt;
endmodule

// File: rtl/lccd_seq.sv
module lccd_seq
  import lccd_pkg::*;
#(
  parameter int N_VACANT  = 26,
  parameter int N_BLACK   = 96,
  parameter int N_INVALID = 6,
  parameter int N_ACTIVE  = 5000,
  parameter int TICK_W    = 8,
  parameter int INTEG_W   = 20,
  parameter int N_COLOUR  = 3,
  localparam int TOTAL    = N_VACANT + N_BLACK + N_INVALID + N_ACTIVE,
  localparam int IDX_W    = $clog2(TOTAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_req,
  input  logic               cfg_hs,
  input  logic [TICK_W-1:0]  cfg_half,
  input  logic [TICK_W-1:0]  cfg_lead,
  input  logic [TICK_W-1:0]  cfg_rst_w,
  input  logic [TICK_W-1:0]  cfg_tg_w,
  input  logic [TICK_W-1:0]  cfg_guard,
  input  logic [INTEG_W-1:0] cfg_integ,
  output logic               sh1,
  output logic               sh2,
  output logic               last1,
  output logic               last2,
  output logic               rst_a,
  output logic               rst_b,
  output logic [N_COLOUR-1:0] tg,
  output logic               smp_valid,
  output logic               smp_odd,
  output logic [1:0]         smp_region,
  output logic [IDX_W-1:0]   smp_idx,
  output logic               line_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  seq_st_t           st;
  logic [TICK_W-1:0] tcnt;
  logic [IDX_W-1:0]  ecnt;
  logic              reading;

  assign reading = (st == ST_READ);

  lccd_line_fsm #(.TICK_W(TICK_W), .INTEG_W(INTEG_W), .TOTAL(TOTAL), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_req(line_req),
    .cfg_half(cfg_half), .cfg_tg_w(cfg_tg_w), .cfg_guard(cfg_guard), .cfg_integ(cfg_integ),
    .st(st), .tcnt(tcnt), .ecnt(ecnt), .line_done(line_done)
  );

  lccd_phase_gen #(.TICK_W(TICK_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .reading(reading), .elem_odd(ecnt[0]), .tcnt(tcnt),
    .cfg_half(cfg_half), .cfg_lead(cfg_lead), .cfg_rst_w(cfg_rst_w), .cfg_hs(cfg_hs),
    .sh1(sh1), .sh2(sh2), .last1(last1), .last2(last2), .rst_a(rst_a), .rst_b(rst_b)
  );

  lccd_tagger #(.TICK_W(TICK_W), .IDX_W(IDX_W), .N_VACANT(N_VACANT),
                .N_BLACK(N_BLACK), .N_INVALID(N_INVALID)) u_tag (
    .reading(reading), .tcnt(tcnt), .ecnt(ecnt), .cfg_half(cfg_half),
    .smp_valid(smp_valid), .smp_odd(smp_odd), .smp_region(smp_region), .smp_idx(smp_idx)
  );

  for (genvar c = 0; c < N_COLOUR; c++) begin : g_tg
    assign tg[c] = (st == ST_TG);
  end

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> ($past(smp_valid) && $past(smp_idx) == LAST_IDX));

  // R3
  static_during_tg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tg[0] |-> (sh1 && !sh2 && !rst_a && !rst_b));
endmodule

// File: tb/lccd_seq_bench.sv
`timescale 1ns/1ps
module lccd_seq_bench;
  localparam int NV = 2, NB = 3, NI = 1, NA = 6;
  localparam int TOT = NV + NB + NI + NA;

  logic clk = 0, rst_n = 0, line_req = 0, cfg_hs = 0;
  logic [7:0] cfg_half = 2, cfg_lead = 1, cfg_rst_w = 1, cfg_tg_w = 1, cfg_guard = 1;
  logic [19:0] cfg_integ = 5;
  logic sh1, sh2, last1, last2, rst_a, rst_b, smp_valid, smp_odd, line_done;
  logic [2:0] tg;
  logic [1:0] smp_region;
  logic [3:0] smp_idx;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  lccd_seq #(.N_VACANT(NV), .N_BLACK(NB), .N_INVALID(NI), .N_ACTIVE(NA)) u_lccd_seq (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .cfg_hs(cfg_hs), .cfg_half(cfg_half),
    .cfg_lead(cfg_lead), .cfg_rst_w(cfg_rst_w), .cfg_tg_w(cfg_tg_w), .cfg_guard(cfg_guard),
    .cfg_integ(cfg_integ), .sh1(sh1), .sh2(sh2), .last1(last1), .last2(last2),
    .rst_a(rst_a), .rst_b(rst_b), .tg(tg), .smp_valid(smp_valid), .smp_odd(smp_odd),
    .smp_region(smp_region), .smp_idx(smp_idx), .line_done(line_done)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // expected outputs at sample n, line starts at b0 and b1
  task automatic check_at(input int n, input int b0, input int b1,
                          input int h, input int hs, input int ld, input int rw,
                          input int g, input int w);
    int n0, ln, r, e, t, es1, es2, el1, el2, era, erb, etg, esv, edn, reg_e;
    n0 = 2 * g + w;
    ln = n0 + TOT * h;
    r  = (n >= b1) ? n - b1 : n - b0;
    es1 = 1; es2 = 0; el1 = 1; el2 = 0; era = 0; erb = 0; etg = 0; esv = 0;
    edn = (r == ln) ? 1 : 0;
    e = 0; t = 0;
    if (r >= 0 && r < ln) begin
      if (r >= g && r < g + w) etg = 7;
      if (r >= n0) begin
        e = (r - n0) / h;
        t = (r - n0) % h;
        es1 = (e % 2 == 0); es2 = !es1;
        el1 = es1 && (hs == 0 || t < h - ld);
        el2 = es2 && (hs == 0 || t < h - ld);
        era = es1 && (t < rw);
        erb = es2 && (t < rw);
        esv = (t == h - 1);
      end
    end
    chk({sh1, sh2}, {es1[0], es2[0]}, "R3 shift phases");
    chk({last1, last2}, {el1[0], el2[0]}, "R4 last-stage clocks");
    chk({rst_a, rst_b}, {era[0], erb[0]}, "R5 reset clocks");
    chk(tg, etg, "R6 transfer gates");
    chk(smp_valid, esv, "R2 sample tick");
    chk(line_done, edn, "R9 line done");
    if (esv != 0) begin
      reg_e = (e < NV) ? 0 : (e < NV + NB) ? 1 : (e < NV + NB + NI) ? 2 : 3;
      chk(smp_idx, e, "R1 element index");
      chk(smp_region, reg_e, "R1 region code");
      chk(smp_odd, e % 2, "R2 odd output select");
    end
    if (r == g - 1 || r == g) chk(tg[0], (r == g), (n >= b1) ? "R8 R7 held start" : "R7 start");
  endtask

  task automatic run_case(input int h, input int hs, input int ld, input int rw,
                          input int g, input int w, input int integ);
    int n0, ln, b1, nend;
    cfg_half = 8'(h); cfg_hs = hs[0]; cfg_lead = 8'(ld); cfg_rst_w = 8'(rw);
    cfg_guard = 8'(g); cfg_tg_w = 8'(w); cfg_integ = 20'(integ);
    repeat (integ + 80) @(negedge clk);
    n0 = 2 * g + w;
    ln = n0 + TOT * h;
    b1 = ((ln > g + w + integ) ? ln : g + w + integ) + 1;
    nend = b1 + ln + 2;
    line_req = 1;
    @(negedge clk);
    for (int n = 0; n <= nend; n++) begin
      check_at(n, 0, b1, h, hs, ld, rw, g, w);
      line_req = (n == n0 + 3);
      @(negedge clk);
    end
    line_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk({sh1, sh2, last1, last2}, 4'b1010, "R10 rest clocks");
    chk({rst_a, rst_b, tg}, 0, "R10 reset and gates low");
    chk({smp_valid, line_done}, 0, "R10 no sample or done");
    run_case(2, 0, 1, 1, 1, 1, 5);
    run_case(3, 1, 1, 1, 2, 3, 60);
    run_case(4, 1, 2, 1, 1, 2, 10);
    run_case(4, 0, 1, 2, 3, 1, 200);
    run_case(5, 1, 3, 1, 2, 2, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule